// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register transactions on a two-wire station management bus. It generates the management clock from the system clock and drives or releases the bidirectional data line, which appears here as three separate signals: an output value, an output enable and the sampled input. A requester places an operation bit, a 5-bit PHY address, a 5-bit register address and 16 bits of write data on the request inputs and pulses `start_i`.

The block then runs one complete frame, MSB first throughout. The frame has a preamble of ones, a start pattern, the opcode, both addresses, a turnaround and 16 data bits. On a read, the block checks the turnaround bit that the PHY must pull low. If that bit is not low, no PHY answered. The block then flushes the bus with 32 released clocks and reports all-ones data with an error flag.

Management clock cycles are numbered from 0, which is the first preamble cycle. Every cycle is a low half followed by a high half. Each half lasts `HALF_CLKS` system clocks, and `HALF_CLKS` may be as small as 1. A bit that the master drives changes only as the low half begins. A bit that the master reads is sampled on the last system clock of the high half.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is running, `mdc_o` is 1, `mdio_oe_o` is 0, `busy_o` and `done_o` are 0. Reset clears `rdata_o` and `err_o` to 0.
- R2: A start accepted at clock edge E sets `busy_o` at E. Counting from E, each management clock cycle is low for `HALF_CLKS` system clocks and then high for `HALF_CLKS` system clocks.
- R3: Cycles 0 to 31 drive the line to 1 with the output enabled.
- R4: Cycles 32 and 33 drive 0 then 1. Cycles 34 and 35 carry the opcode: 1,0 when `rd_i`=1 (read) and 0,1 when `rd_i`=0 (write).
- R5: Cycles 36 to 40 carry `phy_i` MSB first, and cycles 41 to 45 carry `reg_i` MSB first.
- R6: On a write, cycles 46 and 47 drive 1 then 0. Cycles 48 to 63 drive `wdata_i` MSB first. Cycle 64 releases the line. The frame ends after 65 cycles, with `rdata_o`=0 and `err_o`=0.
- R7: On a read, the line is released from cycle 46 onward. The sample taken in cycle 46 must be 0. The samples from cycles 47 to 62 form `rdata_o` MSB first. The frame ends after 65 cycles with `err_o`=0.
- R8: On a read whose cycle-46 sample is 1, the line stays released for 32 further cycles (47 to 78). The frame then ends after 79 cycles with `rdata_o`=16'hFFFF and `err_o`=1.
- R9: `start_i` has no effect while `busy_o` is 1. The running frame continues unchanged.
- R10: A frame ends with a one-cycle `done_o` pulse on the clock where `busy_o` falls, with `mdc_o` left high. `rdata_o` and `err_o` take their results at that edge and keep them. An accepted start clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, taken only when idle |
| rd_i | input | 1 | 1 for a register read, 0 for a register write |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| err_o | output | 1 | Read found no PHY |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The assertions check, on every cycle, that an idle bus has the clock high and the line released, that a frame opens with a low clock and a driven 1, and that once the line is released inside a frame it stays released. They also check that `done_o` is a single pulse that coincides with `busy_o` falling, and that an error always carries all-ones data.

Some behaviour depends on what sits on the line, and only the bench scenarios can show it. This covers the exact bit values in every cycle, the placement of the half-periods, the decoding of both addresses and the opcode by a modelled PHY, the data read back from it, and the absent-PHY flush length. The bench compares every system clock against an independent model. It runs writes, reads, reads to an unmatched address and to a disabled PHY, and a start pulse issued in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned PRE_LEN = 32;
  localparam int unsigned FLUSH_N = 32;
  localparam int unsigned SLOT_W  = 7;

  typedef logic [SLOT_W-1:0] slot_t;

  // Management clock cycle numbers inside one frame.
  localparam slot_t S_START = slot_t'(PRE_LEN);
  localparam slot_t S_OPC   = slot_t'(PRE_LEN + 2);
  localparam slot_t S_PHY   = slot_t'(PRE_LEN + 4);
  localparam slot_t S_REG   = slot_t'(PRE_LEN + 4 + ADDR_W);
  localparam slot_t S_TURN  = slot_t'(PRE_LEN + 4 + 2 * ADDR_W);
  localparam slot_t S_RDAT  = slot_t'(PRE_LEN + 5 + 2 * ADDR_W);
  localparam slot_t S_WDAT  = slot_t'(PRE_LEN + 6 + 2 * ADDR_W);
  localparam slot_t S_LAST  = slot_t'(PRE_LEN + 6 + 2 * ADDR_W + DATA_W);
  localparam slot_t S_FLUSH = slot_t'(PRE_LEN + 4 + 2 * ADDR_W + FLUSH_N);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] rega;
    logic [DATA_W-1:0] wdata;
  } req_t;

endpackage

// File: rtl/mdio_halfcnt.sv
module mdio_halfcnt #(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_end_o
);

  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || (cnt_q == LAST)) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign half_end_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/mdio_txmux.sv
module mdio_txmux
  import mdio_pkg::*;
(
  input  slot_t slot_i,
  input  req_t  req_i,
  output logic  oe_o,
  output logic  o_o
);

  localparam int unsigned AIW = $clog2(ADDR_W);
  localparam int unsigned DIW = $clog2(DATA_W);

  logic [AIW-1:0] phy_off, reg_off;
  logic [DIW-1:0] dat_off;

  always_comb begin
    phy_off = AIW'(slot_i - S_PHY);
    reg_off = AIW'(slot_i - S_REG);
    dat_off = DIW'(slot_i - S_WDAT);
    oe_o    = 1'b1;
    o_o     = 1'b1;
    if (slot_i < S_START) begin
      o_o = 1'b1;
    end else if (slot_i == S_START) begin
      o_o = 1'b0;
    end else if (slot_i < S_OPC) begin
      o_o = 1'b1;
    end else if (slot_i == S_OPC) begin
      o_o = req_i.rd;
    end else if (slot_i < S_PHY) begin
      o_o = !req_i.rd;
    end else if (slot_i < S_REG) begin
      o_o = req_i.phy[AIW'(ADDR_W - 1) - phy_off];
    end else if (slot_i < S_TURN) begin
      o_o = req_i.rega[AIW'(ADDR_W - 1) - reg_off];
    end else if (req_i.rd) begin
      oe_o = 1'b0;
    end else if (slot_i == S_TURN) begin
      o_o = 1'b1;
    end else if (slot_i < S_WDAT) begin
      o_o = 1'b0;
    end else if (slot_i < S_LAST) begin
      o_o = req_i.wdata[DIW'(DATA_W - 1) - dat_off];
    end else begin
      oe_o = 1'b0;
    end
  end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  half_end_i,
  input  logic  rd_i,
  input  logic  line_i,
  output logic  busy_o,
  output logic  busy_next_o,
  output logic  done_o,
  output logic  mdc_o,
  output logic  accept_o,
  output logic  sample_o,
  output logic  finish_o,
  output logic  err_path_o,
  output slot_t slot_o,
  output slot_t slot_next_o
);

  logic  busy_q, busy_d;
  logic  done_q, done_d;
  logic  hi_q, hi_d;
  logic  mdc_q, mdc_d;
  logic  errp_q, errp_d;
  slot_t slot_q, slot_d;
  slot_t last_slot;

  assign accept_o  = start_i && !busy_q;
  assign sample_o  = busy_q && half_end_i && hi_q;
  assign last_slot = errp_q ? S_FLUSH : S_LAST;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    hi_d   = hi_q;
    mdc_d  = mdc_q;
    errp_d = errp_q;
    slot_d = slot_q;
    if (accept_o) begin
      busy_d = 1'b1;
      hi_d   = 1'b0;
      mdc_d  = 1'b0;
      errp_d = 1'b0;
      slot_d = '0;
    end else if (busy_q && half_end_i) begin
      if (!hi_q) begin
        hi_d  = 1'b1;
        mdc_d = 1'b1;
      end else begin
        if (rd_i && (slot_q == S_TURN) && line_i) errp_d = 1'b1;
        if (slot_q == last_slot) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          mdc_d  = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
          hi_d   = 1'b0;
          mdc_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hi_q   <= 1'b1;
      mdc_q  <= 1'b1;
      errp_q <= 1'b0;
      slot_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      hi_q   <= hi_d;
      mdc_q  <= mdc_d;
      errp_q <= errp_d;
      slot_q <= slot_d;
    end
  end

  assign busy_o      = busy_q;
  assign busy_next_o = busy_d;
  assign done_o      = done_q;
  assign mdc_o       = mdc_q;
  assign finish_o    = done_d;
  assign err_path_o  = errp_q;
  assign slot_o      = slot_q;
  assign slot_next_o = slot_d;

endmodule

// File: rtl/mdio_rxcap.sv
module mdio_rxcap
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              rd_i,
  input  logic              err_path_i,
  input  logic              line_i,
  input  slot_t             slot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);

  localparam slot_t S_RDAT_END = slot_t'(S_RDAT + slot_t'(DATA_W));

  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              err_q, err_d;
  logic              in_window;

  assign in_window = (slot_i >= S_RDAT) && (slot_i < S_RDAT_END);

  always_comb begin
    shift_d = shift_q;
    res_d   = res_q;
    err_d   = err_q;
    if (sample_i && rd_i && in_window) shift_d = {shift_q[DATA_W-2:0], line_i};
    if (accept_i) begin
      res_d = '0;
      err_d = 1'b0;
    end else if (finish_i) begin
      err_d = rd_i && err_path_i;
      if (!rd_i)           res_d = '0;
      else if (err_path_i) res_d = '1;
      else                 res_d = shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      res_q   <= res_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = res_q;
  assign err_o   = err_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        err_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic  half_end, accept, sample, finish, err_path, busy_next;
  slot_t slot_q, slot_next;
  req_t  req_q, req_d;
  logic  mux_oe, mux_o;
  logic  oe_q, oe_d, o_q, o_d;

  mdio_halfcnt #(.HALF_CLKS(HALF_CLKS)) u_half (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run_i      (busy_o),
    .half_end_o (half_end)
  );

  mdio_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .half_end_i  (half_end),
    .rd_i        (req_q.rd),
    .line_i      (mdio_i),
    .busy_o      (busy_o),
    .busy_next_o (busy_next),
    .done_o      (done_o),
    .mdc_o       (mdc_o),
    .accept_o    (accept),
    .sample_o    (sample),
    .finish_o    (finish),
    .err_path_o  (err_path),
    .slot_o      (slot_q),
    .slot_next_o (slot_next)
  );

  mdio_txmux u_tx (
    .slot_i (slot_next),
    .req_i  (req_q),
    .oe_o   (mux_oe),
    .o_o    (mux_o)
  );

  mdio_rxcap u_rx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept_i   (accept),
    .sample_i   (sample),
    .finish_i   (finish),
    .rd_i       (req_q.rd),
    .err_path_i (err_path),
    .line_i     (mdio_i),
    .slot_i     (slot_q),
    .rdata_o    (rdata_o),
    .err_o      (err_o)
  );

  always_comb begin
    req_d = req_q;
    if (accept) req_d = '{rd: rd_i, phy: phy_i, rega: reg_i, wdata: wdata_i};
    if (busy_next) begin
      oe_d = mux_oe;
      o_d  = mux_oe ? mux_o : 1'b1;
    end else begin
      oe_d = 1'b0;
      o_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q <= '0;
      oe_q  <= 1'b0;
      o_q   <= 1'b1;
    end else begin
      req_q <= req_d;
      oe_q  <= oe_d;
      o_q   <= o_d;
    end
  end

  assign mdio_oe_o = oe_q;
  assign mdio_o    = o_q;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        err_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (mdc_o && !mdio_oe_o));

  p_frame_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!mdc_o && mdio_oe_o && mdio_o));

  p_release_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mdio_oe_o) |=> !mdio_oe_o);

  p_err_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rdata_o == 16'hFFFF));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int H = 2;
  localparam logic [4:0] MY_PHY = 5'h0B;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd = 1'b0;
  logic [4:0]  pa = '0;
  logic [4:0]  ra = '0;
  logic [15:0] wd = '0;
  logic        busy, done, err, mdc, mdo, mdoe;
  logic [15:0] rdata;
  logic        line;

  // PHY model state
  logic        phy_en = 1'b1;
  logic [15:0] phy_data = 16'h0;
  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b1;
  int          ones = 0;
  int          rc = -1;
  logic [12:0] hdr;
  logic [15:0] wsh;
  logic [15:0] phy_wcap = 16'h0;
  logic [4:0]  phy_pa = '0;
  logic [4:0]  phy_ra = '0;
  logic [1:0]  phy_op = '0;
  logic        phy_answer = 1'b0;

  assign line = mdoe ? mdo : (phy_oe ? phy_val : 1'b1);

  mdio_master #(.HALF_CLKS(H)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(rd), .phy_i(pa),
    .reg_i(ra), .wdata_i(wd), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .err_o(err), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(mdoe), .mdio_i(line)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // PHY: decodes on rising management clock, drives after rising edge.
  always @(posedge mdc) begin
    if (rc < 0) begin
      if (line) ones++;
      else begin
        rc = (ones >= 32) ? 33 : -1;
        ones = 0;
      end
    end else begin
      if (rc <= 45) hdr = {hdr[11:0], line};
      if (rc == 45) begin
        phy_op = hdr[11:10];
        phy_pa = hdr[9:5];
        phy_ra = hdr[4:0];
        phy_answer = phy_en && hdr[12] && (hdr[11:10] == 2'b10) && (hdr[9:5] == MY_PHY);
      end
      if (rc == 46 && phy_answer) begin
        phy_oe  <= 1'b1;
        phy_val <= 1'b0;
      end
      if (rc >= 47 && rc <= 62 && phy_answer) phy_val <= phy_data[62 - rc];
      if (rc >= 48 && rc <= 63) wsh = {wsh[14:0], line};
      if (rc == 63) begin
        phy_oe <= 1'b0;
        if (phy_op == 2'b01) phy_wcap = wsh;
      end
      if (rc == 45 && !phy_answer && hdr[11:10] == 2'b10) begin
        rc = -1;
        ones = 0;
      end else if (rc == 64) begin
        rc = -1;
        ones = 0;
      end else begin
        rc++;
      end
    end
  end

  // Reference model, advanced on every rising system clock.
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_t = 0;
  int          m_len = 65;
  logic [15:0] m_rdata = 16'h0;
  bit          m_err = 1'b0;
  logic [15:0] m_res = 16'h0;
  bit          m_res_err = 1'b0;
  bit          m_rd = 1'b0;
  bit          m_oe [0:79];
  bit          m_o  [0:79];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rdata = 16'h0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == m_len * 2 * H) begin
          m_busy = 0; m_done = 1; m_rdata = m_res; m_err = m_res_err;
        end
      end else if (start) begin
        bit present;
        m_busy = 1; m_t = 0; m_rdata = 16'h0; m_err = 0; m_rd = rd;
        present = !rd || (phy_en && pa == MY_PHY);
        for (int s = 0; s < 80; s++) begin
          m_oe[s] = 1; m_o[s] = 1;
          if (s == 32) m_o[s] = 0;
          else if (s == 34) m_o[s] = rd;
          else if (s == 35) m_o[s] = !rd;
          else if (s >= 36 && s <= 40) m_o[s] = pa[40 - s];
          else if (s >= 41 && s <= 45) m_o[s] = ra[45 - s];
          else if (s >= 46 && rd) m_oe[s] = 0;
          else if (s == 47) m_o[s] = 0;
          else if (s >= 48 && s <= 63) m_o[s] = wd[63 - s];
          else if (s >= 64) m_oe[s] = 0;
        end
        m_len     = present ? 65 : 79;
        m_res     = !rd ? 16'h0 : (present ? phy_data : 16'hFFFF);
        m_res_err = !present;
      end
    end
  end

  function automatic string slot_tag(int s);
    if (s < 32) return "R3";
    if (s < 36) return "R4";
    if (s < 46) return "R5";
    if (!m_rd) return "R6";
    if (m_len == 79 && s > 46) return "R8";
    return "R7";
  endfunction

  bit cmp_en = 1'b0;

  always @(negedge clk) begin
    if (cmp_en) begin
      bit exp_mdc;
      int slot;
      slot = m_t / (2 * H);
      exp_mdc = m_busy ? (((m_t / H) % 2) == 1) : 1'b1;
      chk(mdc == exp_mdc, "R2", "mdc", 32'(mdc), 32'(exp_mdc));
      if (m_busy) begin
        chk(mdoe == m_oe[slot], slot_tag(slot), "oe", 32'(mdoe), 32'(m_oe[slot]));
        if (m_oe[slot]) chk(mdo == m_o[slot], slot_tag(slot), "mdio", 32'(mdo), 32'(m_o[slot]));
      end else begin
        chk(mdoe == 1'b0, "R1", "idle oe", 32'(mdoe), 32'h0);
      end
      chk(busy == m_busy, "R9", "busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R10", "done", 32'(done), 32'(m_done));
      chk({err, rdata} == {m_err, m_rdata}, m_err ? "R8" : "R10", "result",
          32'({err, rdata}), 32'({m_err, m_rdata}));
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic run_op(input bit op_rd, input logic [4:0] op_pa, input logic [4:0] op_ra,
                        input logic [15:0] op_wd, input bit poke,
                        input logic [15:0] exp_data, input bit exp_err, input string tag);
    int k;
    @(negedge clk);
    start = 1; rd = op_rd; pa = op_pa; ra = op_ra; wd = op_wd;
    @(negedge clk);
    start = 0;
    k = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      k++;
      if (poke && k == 40) begin
        start = 1; rd = !op_rd; pa = ~op_pa; ra = ~op_ra; wd = ~op_wd;
      end else if (poke && k == 41) begin
        start = 0;
      end
    end
    chk(rdata == exp_data, tag, "rdata at done", 32'(rdata), 32'(exp_data));
    chk(err == exp_err, tag, "err at done", 32'(err), 32'(exp_err));
    if (!op_rd || exp_err == 1'b0) begin
      chk(phy_ra == op_ra, "R5", "reg addr seen by PHY", 32'(phy_ra), 32'(op_ra));
      chk(phy_pa == op_pa, "R5", "phy addr seen by PHY", 32'(phy_pa), 32'(op_pa));
      chk(phy_op == (op_rd ? 2'b10 : 2'b01), "R4", "opcode seen by PHY",
          32'(phy_op), 32'(op_rd ? 2'b10 : 2'b01));
    end
    if (!op_rd) chk(phy_wcap == op_wd, "R6", "write data at PHY", 32'(phy_wcap), 32'(op_wd));
    repeat (3) @(negedge clk);
    chk(rdata == exp_data && err == exp_err, "R10", "result held",
        32'({err, rdata}), 32'({exp_err, exp_data}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mdc == 1'b1, "R1", "reset mdc", 32'(mdc), 32'h1);
    chk(mdoe == 1'b0, "R1", "reset oe", 32'(mdoe), 32'h0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", 32'({busy, done}), 32'h0);
    chk(rdata == 16'h0 && err == 1'b0, "R1", "reset result", 32'({err, rdata}), 32'h0);
    cmp_en = 1'b1;

    run_op(1'b0, MY_PHY, 5'h00, 16'h8001, 1'b0, 16'h0, 1'b0, "R6");
    run_op(1'b0, MY_PHY, 5'h1F, 16'h7FFE, 1'b0, 16'h0, 1'b0, "R6");
    phy_data = 16'hA5C3;
    run_op(1'b1, MY_PHY, 5'h02, 16'h0, 1'b0, 16'hA5C3, 1'b0, "R7");
    phy_data = 16'h0001;
    run_op(1'b1, MY_PHY, 5'h15, 16'h0, 1'b1, 16'h0001, 1'b0, "R9");
    run_op(1'b1, 5'h1F, 5'h03, 16'h0, 1'b0, 16'hFFFF, 1'b1, "R8");
    phy_data = 16'h8000;
    run_op(1'b1, MY_PHY, 5'h0A, 16'h0, 1'b0, 16'h8000, 1'b0, "R10");
    phy_en = 1'b0;
    run_op(1'b1, MY_PHY, 5'h04, 16'h0, 1'b0, 16'hFFFF, 1'b1, "R8");
    run_op(1'b0, 5'h01, 5'h10, 16'h5AA5, 1'b0, 16'h0, 1'b0, "R6");

    cmp_en = 1'b0;
    summary();
    $finish;
  end

endmodule